// File: doc/BRIEF.md
# Pointer-Addressed Register Read Target with Measurement Trigger and Group Checksum

This block is the serial-bus face of a sensor register bank. It watches the two open-drain lines of an I2C bus as sampled inputs, and it pulls the data line low through one enable output. A controller first addresses the block for writing and sends a single pointer byte. Bit 7 of that byte asks the sensor for a fresh measurement. Bits 6..0 load the register pointer. The controller then issues a repeated START, addresses the block again for reading, and clocks out register contents. The pointer steps forward by one each time the controller acknowledges a register byte.

A checksum enable input selects whether integrity bytes are mixed into the read stream. With it set, each run of four register bytes is followed by one extra byte. That byte is a CRC-8 over those four bytes. The register bank is reached through a plain combinational read port: an address out and data back in the same cycle. A measurement request leaves the block as a single-cycle pulse.

Top module: `i2c_ptr_target`

## Requirements
- R1: The block acknowledges (pulls SDA low in the ninth clock) only an address byte whose upper seven bits equal the parameter DEV_ADDR (default 0x35); bit 0 is R/W with 1 meaning read. For any other address the ninth bit stays released and nothing follows until the next START.
- R2: In a write transfer, bits 6..0 of the byte after the address become the register pointer shown on rd_addr_o. The first byte read afterwards is the register at that pointer.
- R3: If bit 7 of the pointer byte is 1, trig_o pulses once after the pointer byte's acknowledge clock ends. If it is 0, no pulse occurs.
- R4: During a read, each byte is rd_data_i for the current pointer, sent MSB first. The pointer advances by one after every register byte the controller acknowledges.
- R5: The pointer advances from 0x7F to 0x00.
- R6: With crc_en_i high, every fifth byte of a read is a checksum and not register data. The checksum is CRC-8 with polynomial 0x07 and start value 0xFF, processed MSB first, over the four register bytes just sent. It restarts from 0xFF for the next group, and the checksum byte does not advance the pointer.
- R7: With crc_en_i low, only register bytes are sent, with no checksum bytes.
- R8: After the controller leaves a read byte unacknowledged, SDA stays released through any further clocks until the next START.
- R9: A STOP or START clears the group position and the running checksum. Each read therefore starts a fresh group of four.
- R10: The block changes its SDA drive only while SCL is low.
- R11: trig_o is never high for two consecutive clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled level of the bus clock line |
| sda_i | input | 1 | Sampled level of the bus data line |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |
| crc_en_i | input | 1 | 1 inserts a checksum byte after each four register bytes |
| rd_addr_o | output | 7 | Register pointer presented to the register bank |
| rd_data_i | input | 8 | Register contents at rd_addr_o, same cycle |
| trig_o | output | 1 | Single-cycle measurement request |

## Verification
Three events can land on the same falling SCL edge. The trigger pulse is issued as the pointer acknowledge is released. A read byte is loaded at the end of an acknowledge, and a pointer step comes just before it. That load also chooses between a register byte and a checksum byte, and it resets or advances the checksum in the same cycle. Random reads with mixed pointers, trigger bits, lengths and checksum enable are run, together with directed reads that cross 0x7F and cross group edges. Every returned byte and every trigger count is compared with a bench model that tracks address, group position and CRC on its own.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RXDONE,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_NEXT
    } tgt_state_e;

    typedef enum logic [0:0] {
        PH_ADDR,
        PH_PTR
    } rx_phase_e;

    typedef enum logic [1:0] {
        NX_NONE,
        NX_PTR,
        NX_TX,
        NX_DONE
    } after_ack_e;

endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_ff_q;
    logic [STAGES-1:0] sda_ff_q;
    logic              scl_prev_q;
    logic              sda_prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff_q <= '1;
                    sda_ff_q <= '1;
                end else begin
                    scl_ff_q <= scl_i;
                    sda_ff_q <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff_q <= '1;
                    sda_ff_q <= '1;
                end else begin
                    scl_ff_q <= {scl_ff_q[STAGES-2:0], scl_i};
                    sda_ff_q <= {sda_ff_q[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_ff_q[STAGES-1];
            sda_prev_q <= sda_ff_q[STAGES-1];
        end
    end

    assign scl_s    = scl_ff_q[STAGES-1];
    assign sda_s    = sda_ff_q[STAGES-1];
    assign scl_rise = scl_s & ~scl_prev_q;
    assign scl_fall = ~scl_s & scl_prev_q;
    assign start_ev = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_ev  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/crc8_byte.sv
module crc8_byte #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   POLY = 8'h07
) (
    input  logic [W-1:0] crc_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] crc_o
);
    logic [W-1:0] c;

    always_comb begin
        c = crc_i ^ data_i;
        for (int i = 0; i < W; i++) begin
            c = c[W-1] ? ((c << 1) ^ POLY) : (c << 1);
        end
        crc_o = c;
    end
endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target
    import i2c_ptr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h35,
    parameter int         SYNC_STAGES = 2,
    parameter int         GROUP_LEN   = 4,
    parameter logic [7:0] CRC_POLY    = 8'h07,
    parameter logic [7:0] CRC_INIT    = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic       crc_en_i,
    output logic [6:0] rd_addr_o,
    input  logic [7:0] rd_data_i,
    output logic       trig_o
);
    localparam int AW = 7;
    localparam int DW = 8;
    localparam int GW = $clog2(GROUP_LEN + 1);
    localparam int CW = $clog2(DW);

    typedef struct packed {
        tgt_state_e       st;
        rx_phase_e        ph;
        after_ack_e       nx;
        logic [CW-1:0]    cnt;
        logic [DW-1:0]    sh;
        logic [AW-1:0]    ptr;
        logic             trig_req;
        logic             trig;
        logic [GW-1:0]    grp;
        logic [DW-1:0]    crc;
        logic             is_crc;
        logic             drive;
    } regs_t;

    regs_t r_d, r_q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic [DW-1:0] crc_nxt;
    logic [DW-1:0] rx_byte;
    logic          ptr_wr;
    logic          load;

    i2c_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    crc8_byte #(.W(DW), .POLY(CRC_POLY)) u_crc (
        .crc_i  (r_q.crc),
        .data_i (rd_data_i),
        .crc_o  (crc_nxt)
    );

    assign rx_byte = {r_q.sh[DW-2:0], sda_s};

    always_comb begin
        r_d      = r_q;
        r_d.trig = 1'b0;
        ptr_wr   = 1'b0;
        load     = 1'b0;
        if (stop_ev) begin
            r_d.st    = ST_IDLE;
            r_d.drive = 1'b0;
            r_d.grp   = '0;
            r_d.crc   = CRC_INIT;
        end else if (start_ev) begin
            r_d.st    = ST_RX;
            r_d.ph    = PH_ADDR;
            r_d.cnt   = '0;
            r_d.drive = 1'b0;
            r_d.grp   = '0;
            r_d.crc   = CRC_INIT;
        end else begin
            unique case (r_q.st)
                ST_RX: if (scl_rise) begin
                    r_d.sh  = rx_byte;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == CW'(DW - 1)) begin
                        r_d.st = ST_RXDONE;
                        if (r_q.ph == PH_ADDR) begin
                            if (rx_byte[DW-1:1] == DEV_ADDR)
                                r_d.nx = rx_byte[0] ? NX_TX : NX_PTR;
                            else
                                r_d.nx = NX_NONE;
                        end else begin
                            ptr_wr       = 1'b1;
                            r_d.ptr      = rx_byte[AW-1:0];
                            r_d.trig_req = rx_byte[DW-1];
                            r_d.nx       = NX_DONE;
                        end
                    end
                end
                ST_RXDONE: if (scl_fall) begin
                    if (r_q.nx == NX_NONE) begin
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.st    = ST_ACK;
                        r_d.drive = 1'b1;
                    end
                end
                ST_ACK: if (scl_fall) begin
                    r_d.drive = 1'b0;
                    unique case (r_q.nx)
                        NX_PTR: begin
                            r_d.st  = ST_RX;
                            r_d.ph  = PH_PTR;
                            r_d.cnt = '0;
                        end
                        NX_DONE: begin
                            r_d.trig = r_q.trig_req;
                            r_d.st   = ST_IDLE;
                        end
                        NX_TX:   load = 1'b1;
                        default: r_d.st = ST_IDLE;
                    endcase
                end
                ST_TX: if (scl_fall) begin
                    if (r_q.cnt == CW'(DW - 1)) begin
                        r_d.st    = ST_MACK;
                        r_d.drive = 1'b0;
                    end else begin
                        r_d.sh    = r_q.sh << 1;
                        r_d.drive = ~r_q.sh[DW-2];
                        r_d.cnt   = r_q.cnt + 1'b1;
                    end
                end
                ST_MACK: if (scl_rise) begin
                    if (sda_s) begin
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.st = ST_NEXT;
                        if (!r_q.is_crc)
                            r_d.ptr = r_q.ptr + 1'b1;
                    end
                end
                ST_NEXT: if (scl_fall) load = 1'b1;
                default: r_d.st = ST_IDLE;
            endcase
        end

        if (load) begin
            r_d.st  = ST_TX;
            r_d.cnt = '0;
            if (crc_en_i && (r_q.grp == GW'(GROUP_LEN))) begin
                r_d.sh     = r_q.crc;
                r_d.drive  = ~r_q.crc[DW-1];
                r_d.crc    = CRC_INIT;
                r_d.grp    = '0;
                r_d.is_crc = 1'b1;
            end else begin
                r_d.sh     = rd_data_i;
                r_d.drive  = ~rd_data_i[DW-1];
                r_d.crc    = crc_nxt;
                r_d.grp    = (r_q.grp == GW'(GROUP_LEN)) ? GW'(1) : r_q.grp + 1'b1;
                r_d.is_crc = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= ST_IDLE;
            r_q.ph       <= PH_ADDR;
            r_q.nx       <= NX_NONE;
            r_q.crc      <= CRC_INIT;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_pull_o = r_q.drive;
    assign rd_addr_o  = r_q.ptr;
    assign trig_o     = r_q.trig;
endmodule

// File: rtl/i2c_ptr_target_chk.sv
module i2c_ptr_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       stop_ev,
    input logic       ptr_wr,
    input logic       sda_pull_o,
    input logic       trig_o,
    input logic [6:0] rd_addr_o
);
    // R10: drive edges come only from a low SCL
    a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !$past(scl_s));

    // R11: trigger lasts one cycle
    a_r11_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    // R8: bus released after STOP
    a_r8_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_pull_o);

    // R4 / R5: pointer moves by a pointer write or a single modulo step
    a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_addr_o) |-> ($past(ptr_wr) || (rd_addr_o == 7'($past(rd_addr_o) + 7'd1))));

    // R3: trigger raised only as the pointer acknowledge is released
    a_r3_trig_released: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_o) |-> !sda_pull_o);
endmodule

bind i2c_ptr_target i2c_ptr_target_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .stop_ev    (stop_ev),
    .ptr_wr     (ptr_wr),
    .sda_pull_o (sda_pull_o),
    .trig_o     (trig_o),
    .rd_addr_o  (rd_addr_o)
);

// File: tb/sim_i2c_ptr_target.sv
`timescale 1ns/1ps
module sim_i2c_ptr_target;
    localparam int         H    = 16;
    localparam logic [6:0] DEVA = 7'h35;

    function automatic logic [7:0] regval(input logic [6:0] a);
        return {a[3:0], a[6:3]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] x;
        x = c;
        for (int b = 7; b >= 0; b--) begin
            if (x[7] ^ d[b]) x = (x << 1) ^ 8'h07;
            else             x = x << 1;
        end
        return x;
    endfunction

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic scl_c = 1'b1;
    logic sda_c = 1'b1;
    logic crc_en = 1'b0;
    logic sda_pull;
    logic sda_line;
    logic [6:0] rd_addr;
    logic [7:0] rd_data;
    logic trig;

    assign sda_line = sda_c & ~sda_pull;
    assign rd_data  = regval(rd_addr);

    i2c_ptr_target u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_c),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .crc_en_i   (crc_en),
        .rd_addr_o  (rd_addr),
        .rd_data_i  (rd_data),
        .trig_o     (trig)
    );

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int wide_err = 0;
    int hi_err = 0;
    logic trig_prev = 1'b0;
    logic pull_prev = 1'b0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (trig) pulses++;
            if (trig && trig_prev) wide_err++;
            if ((sda_pull !== pull_prev) && scl_c) hi_err++;
        end
        trig_prev <= trig;
        pull_prev <= sda_pull;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_c = 1'b1; scl_c = 1'b1; wclk(H);
        sda_c = 1'b0; wclk(H);
        scl_c = 1'b0; wclk(4);
    endtask

    task automatic bus_rstart();
        sda_c = 1'b1; wclk(H);
        scl_c = 1'b1; wclk(H);
        sda_c = 1'b0; wclk(H);
        scl_c = 1'b0; wclk(4);
    endtask

    task automatic bus_stop();
        sda_c = 1'b0; wclk(H);
        scl_c = 1'b1; wclk(H);
        sda_c = 1'b1; wclk(H);
    endtask

    task automatic put_bit(input logic b);
        sda_c = b; wclk(H);
        scl_c = 1'b1; wclk(H);
        scl_c = 1'b0; wclk(4);
    endtask

    task automatic get_bit(output logic b);
        sda_c = 1'b1; wclk(H);
        scl_c = 1'b1; wclk(H/2);
        b = sda_line; wclk(H/2);
        scl_c = 1'b0; wclk(4);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        acked = ~a;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(~give_ack);
    endtask

    // full pointer write + read; crc_tag names the requirement for checksum bytes
    task automatic do_read(input logic [6:0] ptr, input logic tbit, input int n,
                           input logic ce, input string crc_tag, input bit idle_probe);
        logic ack;
        logic [7:0] got, exp;
        logic [6:0] a;
        logic [7:0] c;
        int g, p0;
        string tag;
        crc_en = ce;
        p0 = pulses;
        bus_start();
        send_byte({DEVA, 1'b0}, ack);
        chk(ack, "R1 write address ack", int'(ack), 1);
        send_byte({tbit, ptr}, ack);
        chk(ack, "R1 pointer ack", int'(ack), 1);
        wclk(8);
        chk((pulses - p0) == int'(tbit), "R3 trigger count", pulses - p0, int'(tbit));
        chk(rd_addr == ptr, "R2 pointer load", int'(rd_addr), int'(ptr));
        bus_rstart();
        send_byte({DEVA, 1'b1}, ack);
        chk(ack, "R1 read address ack", int'(ack), 1);
        a = ptr; c = 8'hFF; g = 0;
        for (int i = 0; i < n; i++) begin
            if (ce && g == 4) begin
                exp = c; c = 8'hFF; g = 0; tag = crc_tag;
            end else begin
                exp = regval(a);
                c = crc_step(c, exp);
                g++;
                if (i == 0)             tag = "R2 first byte";
                else if (!ce && i >= 4) tag = "R7 no checksum";
                else if (a < ptr)       tag = "R5 wrap";
                else                    tag = "R4 stream";
                a = a + 7'd1;
            end
            recv_byte(i != n - 1, got);
            chk(got == exp, tag, int'(got), int'(exp));
        end
        if (idle_probe) begin
            logic b;
            int ones = 0;
            for (int k = 0; k < 9; k++) begin
                get_bit(b);
                if (b) ones++;
            end
            chk(ones == 9, "R8 released after nack", ones, 9);
        end
        bus_stop();
        wclk(8);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 0x0 expected 0x1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic ack;
        int p0;
        int unsigned seed;
        seed = $urandom(32'd1234);
        wclk(5);
        chk(sda_pull == 1'b0, "R10 reset release", int'(sda_pull), 0);
        chk(trig == 1'b0, "R3 reset trigger", int'(trig), 0);
        chk(rd_addr == 7'd0, "R2 reset pointer", int'(rd_addr), 0);
        rst_n = 1'b1;
        wclk(5);

        // R1: foreign addresses get no acknowledge
        p0 = pulses;
        bus_start();
        send_byte({DEVA ^ 7'h11, 1'b0}, ack);
        chk(!ack, "R1 foreign write nack", int'(ack), 0);
        send_byte(8'h85, ack);
        chk(!ack, "R1 ignored after foreign", int'(ack), 0);
        bus_stop();
        chk(pulses == p0, "R3 no trigger on foreign", pulses - p0, 0);
        bus_start();
        send_byte({DEVA ^ 7'h01, 1'b1}, ack);
        chk(!ack, "R1 foreign read nack", int'(ack), 0);
        bus_stop();

        // directed corners
        do_read(7'h10, 1'b1, 3, 1'b0, "R6 checksum", 1'b0);
        do_read(7'h22, 1'b0, 3, 1'b0, "R6 checksum", 1'b0);
        do_read(7'h7D, 1'b0, 6, 1'b0, "R6 checksum", 1'b0);
        do_read(7'h7E, 1'b1, 11, 1'b1, "R6 checksum", 1'b0);
        do_read(7'h05, 1'b0, 8, 1'b0, "R6 checksum", 1'b1);
        do_read(7'h40, 1'b0, 6, 1'b1, "R9 checksum", 1'b0);
        do_read(7'h41, 1'b0, 5, 1'b1, "R9 fresh group checksum", 1'b1);

        // random mix
        for (int t = 0; t < 8; t++) begin
            logic [6:0] p;
            logic tb_bit, ce;
            int n;
            p      = 7'($urandom);
            tb_bit = 1'($urandom);
            ce     = 1'($urandom);
            n      = 1 + int'($urandom % 11);
            do_read(p, tb_bit, n, ce, "R6 checksum", 1'b0);
        end

        chk(wide_err == 0, "R11 single-cycle trigger", wide_err, 0);
        chk(hi_err == 0, "R10 drive change with SCL high", hi_err, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule